// File: doc/BRIEF.md
# Branch Resolution and Squash Unit

This block sits in the execute stage of a single-issue in-order pipeline. It takes one instruction descriptor per cycle. For each descriptor it decides one of four things: the instruction completes, the instruction raises a trap, the branch was mispredicted and younger work must be discarded, or the descriptor is illegal. On a misprediction it issues a fetch redirect together with a squash boundary. The boundary is a sequence number after which all younger instructions are discarded. The squash carries the thread id and the stage number of the branch, so the pipeline can clear the stages behind it and the other resources.

Where the boundary falls depends on three things: the branch kind, whether a conditional delay slot is involved, and the predicted direction. A parameter fixed at elaboration selects whether the instruction set has delay slots. Three wrapping counters record the work done: wrong taken predictions, wrong not-taken predictions, and instructions executed.

The descriptor input is a valid/ready stream, and `in_ready` is held high. The unit never applies back-pressure. A descriptor is consumed on every clock edge where `in_valid` is high. All result outputs are registered and appear one cycle after the descriptor is accepted. The strobes `done_valid`, `squash_valid`, `warn_valid`, `trap_valid` and `error_valid` are high for exactly one cycle per accepted descriptor. The payload that goes with each strobe is meaningful only while that strobe is high.

Top module: `branch_resolve_unit`

## Requirements
- R1: A descriptor of kind memory (`in_kind` = 1) raises `error_valid` for one cycle. It causes no done, squash, warn or trap, and it does not change any counter.
- R2: A mispredicted direct branch (`in_kind` = 2) with `in_cond_dslot` = 1 and `in_pred_taken` = 1 squashes at its own sequence number, redirects to `in_next_pc`, and leaves `dslot_keep` low.
- R3: A mispredicted direct branch with `in_cond_dslot` = 1 and `in_pred_taken` = 0 squashes at its own sequence number, redirects to `in_next_pc`, and raises `dslot_keep`.
- R4: Any other mispredicted direct branch is handled by the delay-slot setting:
  - With delay slots, it squashes at sequence number plus one, modulo 2^SEQ_W, and redirects to `in_next_npc`.
  - Without delay slots, it squashes at its own sequence number and redirects to `in_next_pc`.
- R5: A mispredicted indirect branch (`in_kind` = 3) follows the R4 rule whatever the value of `in_cond_dslot`.
- R6: A misprediction flag on an ALU descriptor (`in_kind` = 0) raises `error_valid` instead of completing. It causes no squash and does not change any counter.
- R7: Every squash pulse copies the descriptor's thread id to `squash_tid` and its stage number to `squash_stage`.
- R8: Each misprediction on a branch increments exactly one counter. `cnt_taken_wrong` counts branches predicted taken, and `cnt_ntaken_wrong` counts those predicted not taken.
- R9: `cnt_exec` increments once for every accepted fault-free or faulting ALU or branch descriptor. Reset clears all three counters.
- R10: A branch with `in_fault` set raises `warn_valid` only. It causes no done and no squash, even when its misprediction flag is set.
- R11: A faulting ALU descriptor raises `trap_valid` with `trap_tid` equal to its thread id, and it does not complete.
- R12: A fault-free ALU descriptor or a fault-free branch produces `done_valid` with `done_seq` equal to its sequence number. A correctly predicted branch produces no squash. When `in_valid` is low, no strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Always high; the unit accepts every cycle |
| in_kind | input | 2 | 0 ALU, 1 memory, 2 direct branch, 3 indirect branch |
| in_seq | input | SEQ_W | Sequence number |
| in_tid | input | TID_W | Thread id |
| in_stage | input | STG_W | Stage number of this unit |
| in_pred_taken | input | 1 | Predicted direction was taken |
| in_cond_dslot | input | 1 | Branch has a conditional delay slot |
| in_mispred | input | 1 | Resolved outcome disagrees with prediction |
| in_fault | input | 1 | Execution raised a fault |
| in_next_pc | input | PC_W | Address following the instruction |
| in_next_npc | input | PC_W | Address two slots after the instruction |
| done_valid | output | 1 | Completion strobe |
| done_seq | output | SEQ_W | Sequence number that completed |
| squash_valid | output | 1 | Misprediction strobe; also qualifies the redirect |
| squash_seq | output | SEQ_W | Squash everything younger than this number |
| squash_stage | output | STG_W | Stage the squash starts from |
| squash_tid | output | TID_W | Thread being squashed |
| redirect_pc | output | PC_W | Fetch redirect target |
| dslot_keep | output | 1 | Delay-slot instruction must still be processed |
| warn_valid | output | 1 | Branch fault warning strobe |
| trap_valid | output | 1 | ALU fault trap strobe |
| trap_tid | output | TID_W | Thread that trapped |
| error_valid | output | 1 | Illegal descriptor strobe |
| cnt_taken_wrong | output | CNT_W | Wrong taken predictions |
| cnt_ntaken_wrong | output | CNT_W | Wrong not-taken predictions |
| cnt_exec | output | CNT_W | Instructions executed |

## Verification
If the outcome decode is wrong, a wrong strobe appears in the very next cycle. Examples are a fault that still completes, or a memory descriptor that gets counted. If the boundary selection is wrong, `squash_seq` and `redirect_pc` are off by one slot on the same strobe. A wrap error at the top sequence number shows up only when a general-rule branch sits at the highest sequence value. If the counter steering is wrong, it persists: the misprediction and execution counters drift away from the sum of the strobes and never recover before reset.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [1:0] {
    KIND_ALU      = 2'd0,
    KIND_MEM      = 2'd1,
    KIND_DIRECT   = 2'd2,
    KIND_INDIRECT = 2'd3
  } kind_e;
endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
(
  input  logic  valid,
  input  kind_e kind,
  input  logic  pred_taken,
  input  logic  cond_dslot,
  input  logic  mispred,
  input  logic  fault,
  output logic  do_done,
  output logic  do_squash,
  output logic  do_warn,
  output logic  do_trap,
  output logic  do_error,
  output logic  do_exec,
  output logic  use_general,
  output logic  keep_dslot
);
  logic is_branch;
  logic cond_direct;

  assign is_branch   = (kind == KIND_DIRECT) || (kind == KIND_INDIRECT);
  assign cond_direct = (kind == KIND_DIRECT) && cond_dslot;
  assign use_general = !cond_direct;

  always_comb begin
    do_done   = 1'b0;
    do_squash = 1'b0;
    do_warn   = 1'b0;
    do_trap   = 1'b0;
    do_error  = 1'b0;
    do_exec   = 1'b0;
    if (valid) begin
      if (kind == KIND_MEM) begin
        do_error = 1'b1;
      end else if (!is_branch && mispred) begin
        do_error = 1'b1;
      end else begin
        do_exec = 1'b1;
        if (fault) begin
          do_warn = is_branch;
          do_trap = !is_branch;
        end else begin
          do_done   = 1'b1;
          do_squash = is_branch && mispred;
        end
      end
    end
  end

  assign keep_dslot = do_squash && cond_direct && !pred_taken;
endmodule

// File: rtl/bru_redirect_calc.sv
module bru_redirect_calc #(
  parameter int SEQ_W      = 8,
  parameter int PC_W       = 32,
  parameter bit DELAY_SLOT = 1'b1
) (
  input  logic [SEQ_W-1:0] seq,
  input  logic [PC_W-1:0]  next_pc,
  input  logic [PC_W-1:0]  next_npc,
  input  logic             use_general,
  output logic [SEQ_W-1:0] bound_seq,
  output logic [PC_W-1:0]  target_pc
);
  logic [SEQ_W-1:0] gen_seq;
  logic [PC_W-1:0]  gen_pc;

  generate
    if (DELAY_SLOT) begin : g_with_slot
      assign gen_seq = seq + 1'b1;
      assign gen_pc  = next_npc;
    end else begin : g_no_slot
      assign gen_seq = seq;
      assign gen_pc  = next_pc;
    end
  endgenerate

  assign bound_seq = use_general ? gen_seq : seq;
  assign target_pc = use_general ? gen_pc  : next_pc;
endmodule

// File: rtl/bru_stat_counters.sv
module bru_stat_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_exec,
  input  logic             inc_taken_wrong,
  input  logic             inc_ntaken_wrong,
  output logic [CNT_W-1:0] cnt_exec,
  output logic [CNT_W-1:0] cnt_taken_wrong,
  output logic [CNT_W-1:0] cnt_ntaken_wrong
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_exec         <= '0;
      cnt_taken_wrong  <= '0;
      cnt_ntaken_wrong <= '0;
    end else begin
      if (inc_exec)         cnt_exec         <= cnt_exec + 1'b1;
      if (inc_taken_wrong)  cnt_taken_wrong  <= cnt_taken_wrong + 1'b1;
      if (inc_ntaken_wrong) cnt_ntaken_wrong <= cnt_ntaken_wrong + 1'b1;
    end
  end
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int SEQ_W      = 8,
  parameter int TID_W      = 2,
  parameter int STG_W      = 3,
  parameter int PC_W       = 32,
  parameter int CNT_W      = 16,
  parameter bit DELAY_SLOT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic [SEQ_W-1:0] in_seq,
  input  logic [TID_W-1:0] in_tid,
  input  logic [STG_W-1:0] in_stage,
  input  logic             in_pred_taken,
  input  logic             in_cond_dslot,
  input  logic             in_mispred,
  input  logic             in_fault,
  input  logic [PC_W-1:0]  in_next_pc,
  input  logic [PC_W-1:0]  in_next_npc,
  output logic             done_valid,
  output logic [SEQ_W-1:0] done_seq,
  output logic             squash_valid,
  output logic [SEQ_W-1:0] squash_seq,
  output logic [STG_W-1:0] squash_stage,
  output logic [TID_W-1:0] squash_tid,
  output logic [PC_W-1:0]  redirect_pc,
  output logic             dslot_keep,
  output logic             warn_valid,
  output logic             trap_valid,
  output logic [TID_W-1:0] trap_tid,
  output logic             error_valid,
  output logic [CNT_W-1:0] cnt_taken_wrong,
  output logic [CNT_W-1:0] cnt_ntaken_wrong,
  output logic [CNT_W-1:0] cnt_exec
);
  logic             d_done, d_squash, d_warn, d_trap, d_error, d_exec;
  logic             d_general, d_keep;
  logic [SEQ_W-1:0] c_seq;
  logic [PC_W-1:0]  c_pc;

  assign in_ready = 1'b1;

  bru_decode u_decode (
    .valid       (in_valid),
    .kind        (kind_e'(in_kind)),
    .pred_taken  (in_pred_taken),
    .cond_dslot  (in_cond_dslot),
    .mispred     (in_mispred),
    .fault       (in_fault),
    .do_done     (d_done),
    .do_squash   (d_squash),
    .do_warn     (d_warn),
    .do_trap     (d_trap),
    .do_error    (d_error),
    .do_exec     (d_exec),
    .use_general (d_general),
    .keep_dslot  (d_keep)
  );

  bru_redirect_calc #(
    .SEQ_W      (SEQ_W),
    .PC_W       (PC_W),
    .DELAY_SLOT (DELAY_SLOT)
  ) u_calc (
    .seq         (in_seq),
    .next_pc     (in_next_pc),
    .next_npc    (in_next_npc),
    .use_general (d_general),
    .bound_seq   (c_seq),
    .target_pc   (c_pc)
  );

  bru_stat_counters #(.CNT_W(CNT_W)) u_stats (
    .clk              (clk),
    .rst_n            (rst_n),
    .inc_exec         (d_exec),
    .inc_taken_wrong  (d_squash && in_pred_taken),
    .inc_ntaken_wrong (d_squash && !in_pred_taken),
    .cnt_exec         (cnt_exec),
    .cnt_taken_wrong  (cnt_taken_wrong),
    .cnt_ntaken_wrong (cnt_ntaken_wrong)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid   <= 1'b0;
      squash_valid <= 1'b0;
      warn_valid   <= 1'b0;
      trap_valid   <= 1'b0;
      error_valid  <= 1'b0;
      dslot_keep   <= 1'b0;
      done_seq     <= '0;
      squash_seq   <= '0;
      squash_stage <= '0;
      squash_tid   <= '0;
      redirect_pc  <= '0;
      trap_tid     <= '0;
    end else begin
      done_valid   <= d_done;
      squash_valid <= d_squash;
      warn_valid   <= d_warn;
      trap_valid   <= d_trap;
      error_valid  <= d_error;
      dslot_keep   <= d_keep;
      if (d_done) done_seq <= in_seq;
      if (d_squash) begin
        squash_seq   <= c_seq;
        squash_stage <= in_stage;
        squash_tid   <= in_tid;
        redirect_pc  <= c_pc;
      end
      if (d_trap) trap_tid <= in_tid;
    end
  end

  logic [CNT_W-1:0] mis_sum;
  assign mis_sum = cnt_taken_wrong + cnt_ntaken_wrong;

  assert_mem_never_completes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    error_valid |-> (!done_valid && !squash_valid && !trap_valid && !warn_valid));

  assert_dslot_needs_squash_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dslot_keep |-> squash_valid);

  assert_miscount_tracks_squash_R8: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> (mis_sum == CNT_W'($past(mis_sum) + 1'b1)));

  assert_miscount_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!squash_valid && $past(rst_n)) |-> $stable(mis_sum));

  assert_exec_tracks_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid || warn_valid || trap_valid) |-> (cnt_exec == CNT_W'($past(cnt_exec) + 1'b1)));

  assert_fault_blocks_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid || warn_valid) |-> (!done_valid && !squash_valid));
endmodule

// File: tb/branch_resolve_unit_bench.sv
module branch_resolve_unit_bench;
  localparam int SEQ_W = 8, TID_W = 2, STG_W = 3, PC_W = 32, CNT_W = 16;
  localparam int NV = 13;
  // {kind[21:20], pred_taken[19], cond_dslot[18], mispred[17], fault[16],
  //  seq[15:8], tid[7:6], stage[5:3], expected outcome[2:0]}
  // outcome: 1 done, 2 done+squash, 3 warn, 4 trap, 5 error
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd10,  2'd1, 3'd2, 3'd1},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd11,  2'd2, 3'd2, 3'd4},
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd12,  2'd0, 3'd2, 3'd5},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'd13,  2'd0, 3'd2, 3'd1},
    {2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 8'd14,  2'd1, 3'd3, 3'd2},
    {2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 8'd15,  2'd2, 3'd4, 3'd2},
    {2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 8'd16,  2'd3, 3'd1, 3'd2},
    {2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 8'd255, 2'd0, 3'd6, 3'd2},
    {2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 8'd20,  2'd3, 3'd5, 3'd2},
    {2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 8'd21,  2'd1, 3'd5, 3'd3},
    {2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd22,  2'd1, 3'd2, 3'd5},
    {2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 8'd23,  2'd2, 3'd2, 3'd5},
    {2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 8'd24,  2'd0, 3'd2, 3'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             in_valid = 1'b0;
  logic [1:0]       in_kind = '0;
  logic [SEQ_W-1:0] in_seq = '0;
  logic [TID_W-1:0] in_tid = '0;
  logic [STG_W-1:0] in_stage = '0;
  logic             in_pred_taken = 1'b0, in_cond_dslot = 1'b0, in_mispred = 1'b0, in_fault = 1'b0;
  logic [PC_W-1:0]  in_next_pc = '0, in_next_npc = '0;

  logic             a_ready, a_done, a_squash, a_dslot, a_warn, a_trap, a_error;
  logic [SEQ_W-1:0] a_done_seq, a_sq_seq;
  logic [STG_W-1:0] a_sq_stage;
  logic [TID_W-1:0] a_sq_tid, a_trap_tid;
  logic [PC_W-1:0]  a_rpc;
  logic [CNT_W-1:0] a_ctw, a_cntw, a_cex;

  logic             b_ready, b_done, b_squash, b_dslot, b_warn, b_trap, b_error;
  logic [SEQ_W-1:0] b_done_seq, b_sq_seq;
  logic [STG_W-1:0] b_sq_stage;
  logic [TID_W-1:0] b_sq_tid, b_trap_tid;
  logic [PC_W-1:0]  b_rpc;
  logic [CNT_W-1:0] b_ctw, b_cntw, b_cex;

  branch_resolve_unit #(.DELAY_SLOT(1'b1)) u_branch_resolve_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(a_ready),
    .in_kind(in_kind), .in_seq(in_seq), .in_tid(in_tid), .in_stage(in_stage),
    .in_pred_taken(in_pred_taken), .in_cond_dslot(in_cond_dslot),
    .in_mispred(in_mispred), .in_fault(in_fault),
    .in_next_pc(in_next_pc), .in_next_npc(in_next_npc),
    .done_valid(a_done), .done_seq(a_done_seq), .squash_valid(a_squash),
    .squash_seq(a_sq_seq), .squash_stage(a_sq_stage), .squash_tid(a_sq_tid),
    .redirect_pc(a_rpc), .dslot_keep(a_dslot), .warn_valid(a_warn),
    .trap_valid(a_trap), .trap_tid(a_trap_tid), .error_valid(a_error),
    .cnt_taken_wrong(a_ctw), .cnt_ntaken_wrong(a_cntw), .cnt_exec(a_cex));

  branch_resolve_unit #(.DELAY_SLOT(1'b0)) u_branch_resolve_unit_noslot (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(b_ready),
    .in_kind(in_kind), .in_seq(in_seq), .in_tid(in_tid), .in_stage(in_stage),
    .in_pred_taken(in_pred_taken), .in_cond_dslot(in_cond_dslot),
    .in_mispred(in_mispred), .in_fault(in_fault),
    .in_next_pc(in_next_pc), .in_next_npc(in_next_npc),
    .done_valid(b_done), .done_seq(b_done_seq), .squash_valid(b_squash),
    .squash_seq(b_sq_seq), .squash_stage(b_sq_stage), .squash_tid(b_sq_tid),
    .redirect_pc(b_rpc), .dslot_keep(b_dslot), .warn_valid(b_warn),
    .trap_valid(b_trap), .trap_tid(b_trap_tid), .error_valid(b_error),
    .cnt_taken_wrong(b_ctw), .cnt_ntaken_wrong(b_cntw), .cnt_exec(b_cex));

  int n_checks = 0;
  int n_fail = 0;
  int e_tw = 0, e_ntw = 0, e_ex = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_counters(input string req);
    chk(req, "cnt_taken_wrong", a_ctw, e_tw);
    chk(req, "cnt_ntaken_wrong", a_cntw, e_ntw);
    chk(req, "cnt_exec", a_cex, e_ex);
    chk(req, "noslot cnt_taken_wrong", b_ctw, e_tw);
    chk(req, "noslot cnt_ntaken_wrong", b_cntw, e_ntw);
    chk(req, "noslot cnt_exec", b_cex, e_ex);
  endtask

  task automatic chk_quiet(input string req);
    chk(req, "strobes", {a_done, a_squash, a_warn, a_trap, a_error}, 5'b0);
    chk(req, "noslot strobes", {b_done, b_squash, b_warn, b_trap, b_error}, 5'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state (R9 counters cleared, R12 no strobes)
    chk_quiet("R12");
    chk_counters("R9");
    chk("R12", "in_ready", a_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      logic [2:0]  eo;
      logic        general;
      logic [7:0]  sq;
      v = VEC[i];
      eo = v[2:0];
      sq = v[15:8];
      in_valid      = 1'b1;
      in_kind       = v[21:20];
      in_pred_taken = v[19];
      in_cond_dslot = v[18];
      in_mispred    = v[17];
      in_fault      = v[16];
      in_seq        = sq;
      in_tid        = v[7:6];
      in_stage      = v[5:3];
      in_next_pc    = 32'h1000 + 32'(sq) * 4;
      in_next_npc   = 32'h1000 + 32'(sq) * 4 + 4;
      @(negedge clk);
      // Expected from requirements R1..R12
      chk("R12", $sformatf("v%0d done", i), a_done, (eo == 3'd1 || eo == 3'd2));
      chk("R2",  $sformatf("v%0d squash", i), a_squash, (eo == 3'd2));
      chk("R10", $sformatf("v%0d warn", i), a_warn, (eo == 3'd3));
      chk("R11", $sformatf("v%0d trap", i), a_trap, (eo == 3'd4));
      chk("R1",  $sformatf("v%0d error", i), a_error, (eo == 3'd5));
      chk("R6",  $sformatf("v%0d noslot strobes", i),
          {b_done, b_squash, b_warn, b_trap, b_error},
          {a_done, a_squash, a_warn, a_trap, a_error});
      if (eo == 3'd1 || eo == 3'd2) chk("R12", "done_seq", a_done_seq, sq);
      if (eo == 3'd4) chk("R11", "trap_tid", a_trap_tid, v[7:6]);
      if (eo == 3'd2) begin
        general = !(v[21:20] == 2'd2 && v[18]);
        if (general) begin
          chk("R4", "slot squash_seq", a_sq_seq, 8'(sq + 8'd1));
          chk("R5", "slot redirect", a_rpc, in_next_npc);
        end else begin
          chk("R2", "slot squash_seq", a_sq_seq, sq);
          chk("R2", "slot redirect", a_rpc, in_next_pc);
        end
        chk("R4", "noslot squash_seq", b_sq_seq, sq);
        chk("R4", "noslot redirect", b_rpc, in_next_pc);
        chk("R3", "dslot_keep", a_dslot, (!general && !v[19]));
        chk("R3", "noslot dslot_keep", b_dslot, (!general && !v[19]));
        chk("R7", "squash_tid", a_sq_tid, v[7:6]);
        chk("R7", "squash_stage", a_sq_stage, v[5:3]);
        if (v[19]) e_tw++; else e_ntw++;
      end
      if (eo >= 3'd1 && eo <= 3'd4) e_ex++;
      chk_counters("R8");
    end

    // Idle cycle with misprediction-looking data: ignored (R12)
    in_valid = 1'b0;
    in_kind = 2'd2;
    in_mispred = 1'b1;
    @(negedge clk);
    chk_quiet("R12");
    chk_counters("R12");
    chk("R8", "final taken-wrong", e_tw, 3);
    chk("R8", "final ntaken-wrong", e_ntw, 2);
    chk("R9", "final exec", e_ex, 10);

    // Back-to-back mispredictions on consecutive cycles (R8, R7)
    in_valid = 1'b1; in_kind = 2'd3; in_fault = 1'b0; in_pred_taken = 1'b1;
    in_seq = 8'd40; in_tid = 2'd2; in_stage = 3'd7;
    @(negedge clk);
    e_tw++; e_ex++;
    chk("R7", "b2b squash_stage", a_sq_stage, 7);
    in_pred_taken = 1'b0; in_seq = 8'd41;
    @(negedge clk);
    e_ntw++; e_ex++;
    chk("R8", "b2b squash", a_squash, 1);
    chk("R4", "b2b squash_seq", a_sq_seq, 42);
    chk_counters("R8");

    // Reset mid-run clears counters (R9)
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    e_tw = 0; e_ntw = 0; e_ex = 0;
    chk_counters("R9");
    chk_quiet("R9");
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule